// File: doc/BRIEF.md
# Ethernet Controller Register Front End with Interrupt Logic

This block is the host-facing control and status register set of a small Ethernet controller. The host reaches it through two bus locations. The pointer location holds the index of a control/status register. The data location reads or writes whichever register that index selects. Three registers exist: the main control/status word (index 0), an interrupt-mask word (index 3) and a mode word (index 15) that carries the promiscuous flag.

The receive, transmit and initialisation engines report completions and error conditions to the block as single-cycle pulses. The block records them as sticky status flags. It derives a summary interrupt flag and a level-sensitive interrupt request from those flags. It also sends one-cycle start, stop and init strobes back to the engines. The stop strobe also tells the ring logic to return its receive and transmit positions to zero. A frame-accept output combines the address filter's match result with the promiscuous flag.

Top module: `nic_csr_regs`

## Requirements
- R1: After reset, the control/status word reads 0x0004 (only STOP, bit 2, set). The mask word, the mode word and the pointer read 0. irqOut, startStrobe, stopStrobe and initStrobe are low.
- R2: A write at byte offset 0x14 loads the pointer, and a read there returns it. Reads and writes at offset 0x10 reach the register the pointer selects. An index other than 0, 3 or 15, or any other offset, reads 0, and writes to it change nothing.
- R3: A control/status write with bit 2 set makes the word read exactly 0x0004, whatever else was written. stopStrobe is high for the one cycle after that write.
- R4: Bits 8 (IDON), 11 (MERR), 12 (MISS), 13 (CERR) and 14 (BABL) clear when a non-stop write puts a 1 in their position. A 0 leaves them unchanged. Bit 15 reads as the OR of bits 11 to 14.
- R5: A modulo-3 counter advances on every non-stop control/status write. Bits 9 (TINT) and 10 (RINT) are clearable only on the write that wraps the counter, which is every third such write.
- R6: rxDone sets bit 10, txDone sets bit 9 and initDone sets bit 8. errEvt[0..3] set bits 11, 12, 13 and 14 respectively. An event that arrives in the same cycle as a clearing write leaves its bit set.
- R7: INTR (bit 7) is the OR of status bits 8 to 12, each taken only where mask-word bit 8 to 12 is 0. It is recomputed only on a control/status write or an event, so a mask write alone leaves it as it was. Bits 13 and 14 never raise it.
- R8: irqOut equals INTR AND IENA (bit 6). IENA takes the written bit 6 on every non-stop write, and a stop write clears it.
- R9: A write with bit 1 set while STOP is set clears STOP, sets RXON (bit 5) and TXON (bit 4), and raises startStrobe for one cycle. Bit 1 written while running changes nothing and raises no strobe.
- R10: A non-stop write with bit 0 set raises initStrobe for the next cycle. Bits 0, 1 and 3 always read 0.
- R11: The mode word stores only bit 15 (promiscuous) and the mask word only bits 8 to 12. frameAccept is high when the promiscuous bit is set or frameAddrMatch is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Host write enable for this cycle |
| busAddr | input | 5 | Byte offset of the host access |
| busWrData | input | 16 | Host write data |
| busRdData | output | 16 | Host read data for busAddr, combinational |
| rxDone | input | 1 | Receive completion pulse |
| txDone | input | 1 | Transmit completion pulse |
| initDone | input | 1 | Initialisation completion pulse |
| errEvt | input | 4 | Error pulses: memory, missed frame, collision, babble |
| frameAddrMatch | input | 1 | Address filter hit for the current frame |
| irqOut | output | 1 | Level interrupt request |
| frameAccept | output | 1 | Frame accepted by filter or promiscuous mode |
| startStrobe | output | 1 | One-cycle start command |
| stopStrobe | output | 1 | One-cycle stop command and ring position clear |
| initStrobe | output | 1 | One-cycle init command |

## Verification
The assertions assume that event pulses and host writes are sampled synchronously. They also assume that a stop write never coincides with an event, because the stop write wipes the whole status word. The stimulus always issues stop writes on their own, with every event line low, and applies event combinations only in separate cycles or together with non-stop writes. The sweep loads every mask value. For each one it clears the state, enables interrupts and then injects every one of the 128 event patterns.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  // control/status word bit positions (software decodes them)
  localparam int BIT_INIT = 0;
  localparam int BIT_STRT = 1;
  localparam int BIT_STOP = 2;
  localparam int BIT_IENA = 6;
  localparam int BIT_INTR = 7;
  localparam int ST_LO    = 8;   // first sticky status bit
  localparam int ST_N     = 7;   // sticky status bits 8..14
  localparam int MSK_N    = 5;   // maskable status bits 8..12
  localparam int IDX_MAIN = 0;
  localparam int IDX_MASK = 3;
  localparam int IDX_MODE = 15;

  typedef struct packed {
    logic wrMain;
    logic wrMask;
    logic wrMode;
    logic wrPtr;
    logic stopHit;
    logic startHit;
    logic initHit;
    logic clrRxTx;
  } csrCtl_t;
endpackage

// File: rtl/nic_csr_ctrl.sv
module nic_csr_ctrl
  import nic_csr_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int RAP_W      = 7,
  parameter int PTR_OFFS   = 'h14,
  parameter int DATA_OFFS  = 'h10,
  parameter int CLR_PERIOD = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [RAP_W-1:0]  rapQ,
  input  logic              stoppedQ,
  output csrCtl_t           ctl,
  output logic              startStrobe,
  output logic              stopStrobe,
  output logic              initStrobe
);
  localparam int CNT_W = (CLR_PERIOD > 1) ? $clog2(CLR_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLR_PERIOD - 1);

  logic [CNT_W-1:0] clrCnt;
  logic dataWr, nonStopWr;

  always_comb begin
    dataWr       = busWrEn && (busAddr == ADDR_W'(DATA_OFFS));
    ctl          = '0;
    ctl.wrPtr    = busWrEn && (busAddr == ADDR_W'(PTR_OFFS));
    ctl.wrMain   = dataWr && (rapQ == RAP_W'(IDX_MAIN));
    ctl.wrMask   = dataWr && (rapQ == RAP_W'(IDX_MASK));
    ctl.wrMode   = dataWr && (rapQ == RAP_W'(IDX_MODE));
    ctl.stopHit  = ctl.wrMain && busWrData[BIT_STOP];
    nonStopWr    = ctl.wrMain && !busWrData[BIT_STOP];
    ctl.clrRxTx  = nonStopWr && (clrCnt == CNT_LAST);
    ctl.startHit = nonStopWr && busWrData[BIT_STRT] && stoppedQ;
    ctl.initHit  = nonStopWr && busWrData[BIT_INIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clrCnt      <= '0;
      startStrobe <= 1'b0;
      stopStrobe  <= 1'b0;
      initStrobe  <= 1'b0;
    end else begin
      if (nonStopWr) clrCnt <= (clrCnt == CNT_LAST) ? '0 : clrCnt + 1'b1;
      startStrobe <= ctl.startHit;
      stopStrobe  <= ctl.stopHit;
      initStrobe  <= ctl.initHit;
    end
  end
endmodule

// File: rtl/nic_csr_datapath.sv
module nic_csr_datapath
  import nic_csr_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int RAP_W     = 7,
  parameter int PTR_OFFS  = 'h14,
  parameter int DATA_OFFS = 'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrCtl_t           ctl,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              rxDone,
  input  logic              txDone,
  input  logic              initDone,
  input  logic [3:0]        errEvt,
  input  logic              frameAddrMatch,
  output logic [RAP_W-1:0]  rapQ,
  output logic              stoppedQ,
  output logic [DATA_W-1:0] mainView,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut,
  output logic              frameAccept
);
  // status index 0..6 = IDON, TINT, RINT, MERR, MISS, CERR, BABL
  localparam logic [ST_N-1:0] ALWAYS_CLR = 7'b1111001;
  localparam logic [ST_N-1:0] RXTX_CLR   = 7'b0000110;

  logic [ST_N-1:0]  stQ, stN, evSet, w1c;
  logic [MSK_N-1:0] maskQ;
  logic promQ, ienaQ, rxOnQ, txOnQ, intrQ, intrN;
  logic [DATA_W-1:0] selData;

  always_comb begin
    evSet = {errEvt, rxDone, txDone, initDone};
    w1c   = ALWAYS_CLR | (ctl.clrRxTx ? RXTX_CLR : '0);
    w1c   = ctl.wrMain ? (w1c & busWrData[ST_LO +: ST_N]) : '0;
    stN   = (stQ & ~w1c) | evSet;
    intrN = |(stN[MSK_N-1:0] & ~maskQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rapQ <= '0; maskQ <= '0; promQ <= 1'b0;
      stQ <= '0; ienaQ <= 1'b0; rxOnQ <= 1'b0; txOnQ <= 1'b0;
      stoppedQ <= 1'b1; intrQ <= 1'b0;
    end else begin
      if (ctl.wrPtr)  rapQ  <= busWrData[RAP_W-1:0];
      if (ctl.wrMask) maskQ <= busWrData[ST_LO +: MSK_N];
      if (ctl.wrMode) promQ <= busWrData[DATA_W-1];
      if (ctl.stopHit) begin
        stQ <= '0; ienaQ <= 1'b0; rxOnQ <= 1'b0; txOnQ <= 1'b0;
        stoppedQ <= 1'b1; intrQ <= 1'b0;
      end else begin
        stQ <= stN;
        if (ctl.wrMain) ienaQ <= busWrData[BIT_IENA];
        if (ctl.startHit) begin
          stoppedQ <= 1'b0; rxOnQ <= 1'b1; txOnQ <= 1'b1;
        end
        if (ctl.wrMain || (|evSet)) intrQ <= intrN;
      end
    end
  end

  always_comb begin
    mainView = {|stQ[ST_N-1:3], stQ, intrQ, ienaQ, rxOnQ, txOnQ, 1'b0, stoppedQ, 2'b00};
    unique case (rapQ)
      RAP_W'(IDX_MAIN): selData = mainView;
      RAP_W'(IDX_MASK): selData = DATA_W'({maskQ, 8'h00});
      RAP_W'(IDX_MODE): selData = {promQ, {(DATA_W-1){1'b0}}};
      default:          selData = '0;
    endcase
    if (busAddr == ADDR_W'(PTR_OFFS))       busRdData = DATA_W'(rapQ);
    else if (busAddr == ADDR_W'(DATA_OFFS)) busRdData = selData;
    else                                    busRdData = '0;
    irqOut      = intrQ && ienaQ;
    frameAccept = promQ || frameAddrMatch;
  end
endmodule

// File: rtl/nic_csr_regs.sv
module nic_csr_regs
  import nic_csr_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int RAP_W      = 7,
  parameter int PTR_OFFS   = 'h14,
  parameter int DATA_OFFS  = 'h10,
  parameter int CLR_PERIOD = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              rxDone,
  input  logic              txDone,
  input  logic              initDone,
  input  logic [3:0]        errEvt,
  input  logic              frameAddrMatch,
  output logic              irqOut,
  output logic              frameAccept,
  output logic              startStrobe,
  output logic              stopStrobe,
  output logic              initStrobe
);
  csrCtl_t ctl;
  logic [RAP_W-1:0]  rapQ;
  logic              stoppedQ;
  logic [DATA_W-1:0] mainView;

  nic_csr_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAP_W(RAP_W),
    .PTR_OFFS(PTR_OFFS), .DATA_OFFS(DATA_OFFS), .CLR_PERIOD(CLR_PERIOD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .rapQ(rapQ), .stoppedQ(stoppedQ), .ctl(ctl),
    .startStrobe(startStrobe), .stopStrobe(stopStrobe), .initStrobe(initStrobe)
  );

  nic_csr_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAP_W(RAP_W),
    .PTR_OFFS(PTR_OFFS), .DATA_OFFS(DATA_OFFS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busAddr(busAddr), .busWrData(busWrData),
    .rxDone(rxDone), .txDone(txDone), .initDone(initDone), .errEvt(errEvt),
    .frameAddrMatch(frameAddrMatch), .rapQ(rapQ), .stoppedQ(stoppedQ),
    .mainView(mainView), .busRdData(busRdData), .irqOut(irqOut),
    .frameAccept(frameAccept)
  );
endmodule

// File: rtl/nic_csr_chk.sv
module nic_csr_chk #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int RAP_W     = 7,
  parameter int DATA_OFFS = 'h10
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [RAP_W-1:0]  rapQ,
  input logic [DATA_W-1:0] mainView,
  input logic              rxDone,
  input logic              txDone,
  input logic              initDone,
  input logic [3:0]        errEvt,
  input logic              irqOut,
  input logic              startStrobe,
  input logic              stopStrobe,
  input logic              initStrobe
);
  logic mainWr;
  assign mainWr = busWrEn && (busAddr == ADDR_W'(DATA_OFFS)) && (rapQ == '0);

  // R3
  stop_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mainWr && busWrData[2]) |=> (stopStrobe && mainView == 16'h0004));

  // R10
  init_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mainWr && busWrData[0] && !busWrData[2]) |=> initStrobe);

  // R8
  irq_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopStrobe |-> !irqOut);

  // R6
  rx_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && !(mainWr && busWrData[2])) |=> mainView[10]);

  // R7
  intr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!mainWr && !rxDone && !txDone && !initDone && errEvt == 4'h0) |=> $stable(mainView[7]));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startStrobe, stopStrobe}));
endmodule

bind nic_csr_regs nic_csr_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAP_W(RAP_W), .DATA_OFFS(DATA_OFFS)
) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .rapQ(rapQ), .mainView(mainView), .rxDone(rxDone),
  .txDone(txDone), .initDone(initDone), .errEvt(errEvt), .irqOut(irqOut),
  .startStrobe(startStrobe), .stopStrobe(stopStrobe), .initStrobe(initStrobe)
);

// File: tb/tb_nic_csr_regs.sv
`timescale 1ns/1ps
module tb_nic_csr_regs;
  localparam logic [4:0] PTR = 5'h14;
  localparam logic [4:0] DAT = 5'h10;

  logic clk = 1'b0, rstN = 1'b0, busWrEn = 1'b0;
  logic [4:0] busAddr = '0;
  logic [15:0] busWrData = '0, busRdData;
  logic rxDone = 0, txDone = 0, initDone = 0, frameAddrMatch = 0;
  logic [3:0] errEvt = '0;
  logic irqOut, frameAccept, startStrobe, stopStrobe, initStrobe;

  int nChk = 0, nFail = 0;

  // bench model of the requirements
  logic [6:0] mSt = '0;
  logic [4:0] mMask = '0;
  logic mIena = 0, mRx = 0, mTx = 0, mStop = 1, mIntr = 0;
  int mCnt = 0;

  always #2.5 clk = ~clk;

  nic_csr_regs dut (.*);

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expMain();
    return {|mSt[6:3], mSt, mIntr, mIena, mRx, mTx, 1'b0, mStop, 2'b00};
  endfunction

  // one bus cycle, entered and left at a falling edge
  task automatic busCycle(input logic we, input logic [4:0] a, input logic [15:0] d,
                          input logic [6:0] ev);
    busWrEn = we; busAddr = a; busWrData = d;
    {errEvt, rxDone, txDone, initDone} = ev;
    @(negedge clk);
    busWrEn = 0; {errEvt, rxDone, txDone, initDone} = '0;
  endtask

  task automatic modelMain(input logic [15:0] d, input logic [6:0] ev);
    logic [6:0] m;
    if (d[2]) begin
      mSt = '0; mIena = 0; mRx = 0; mTx = 0; mStop = 1; mIntr = 0;
    end else begin
      m = 7'b1111001 | ((mCnt == 2) ? 7'b0000110 : 7'b0);
      mCnt = (mCnt == 2) ? 0 : mCnt + 1;
      mSt = (mSt & ~(d[14:8] & m)) | ev;
      mIena = d[6];
      if (d[1] && mStop) begin mStop = 0; mRx = 1; mTx = 1; end
      mIntr = |(mSt[4:0] & ~mMask);
    end
  endtask

  task automatic wrMain(input logic [15:0] d, input logic [6:0] ev);
    busCycle(1'b1, DAT, d, ev);
    modelMain(d, ev);
  endtask

  task automatic events(input logic [6:0] ev);
    busCycle(1'b0, DAT, 16'h0, ev);
    mSt = mSt | ev;
    if (ev != 0) mIntr = |(mSt[4:0] & ~mMask);
  endtask

  task automatic wrIdx(input logic [6:0] idx, input logic [15:0] d);
    busCycle(1'b1, PTR, {9'b0, idx}, '0);
    busCycle(1'b1, DAT, d, '0);
    busCycle(1'b1, PTR, 16'h0, '0);
  endtask

  task automatic rdAt(input logic [4:0] a, output logic [15:0] v);
    busAddr = a; #1; v = busRdData;
  endtask

  task automatic rdIdx(input logic [6:0] idx, output logic [15:0] v);
    busCycle(1'b1, PTR, {9'b0, idx}, '0);
    rdAt(DAT, v);
    busCycle(1'b1, PTR, 16'h0, '0);
  endtask

  task automatic chkMain(input string tag);
    logic [15:0] v;
    rdAt(DAT, v);
    check(v, expMain(), tag);
    check({15'b0, irqOut}, {15'b0, mIntr & mIena}, "R8 irqOut");
  endtask

  initial begin
    logic [15:0] v;
    int clears;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rdAt(PTR, v);   check(v, 16'h0000, "R1 pointer");
    rdAt(DAT, v);   check(v, 16'h0004, "R1 main word");
    rdIdx(3, v);    check(v, 16'h0000, "R1 mask word");
    rdIdx(15, v);   check(v, 16'h0000, "R1 mode word");
    check({12'b0, irqOut, startStrobe, stopStrobe, initStrobe}, 16'h0, "R1 outputs");

    // R2 pointer and unimplemented indices
    busCycle(1'b1, PTR, 16'h0007, '0);
    rdAt(PTR, v);   check(v, 16'h0007, "R2 pointer readback");
    busCycle(1'b1, DAT, 16'hFFFF, '0);
    rdAt(DAT, v);   check(v, 16'h0000, "R2 unimplemented index");
    busCycle(1'b1, 5'h00, 16'hFFFF, '0);
    rdAt(5'h00, v); check(v, 16'h0000, "R2 other offset");
    busCycle(1'b1, PTR, 16'h0000, '0);
    chkMain("R2 main untouched");
    rdIdx(3, v);    check(v, 16'h0000, "R2 mask untouched");

    // R11 mode and mask storage, filter
    wrIdx(15, 16'hFFFF);
    rdIdx(15, v);   check(v, 16'h8000, "R11 mode bits");
    frameAddrMatch = 0; #1;
    check({15'b0, frameAccept}, 16'h1, "R11 promiscuous accept");
    wrIdx(15, 16'h0000);
    #1; check({15'b0, frameAccept}, 16'h0, "R11 no match");
    frameAddrMatch = 1; #1;
    check({15'b0, frameAccept}, 16'h1, "R11 match");
    frameAddrMatch = 0;
    wrIdx(3, 16'hFFFF);
    rdIdx(3, v);    check(v, 16'h1F00, "R11 mask bits");
    wrIdx(3, 16'h0000); mMask = '0;

    // R9 start
    wrMain(16'h0042, '0);
    check({15'b0, startStrobe}, 16'h1, "R9 start strobe");
    chkMain("R9 running");
    wrMain(16'h0042, '0);
    check({15'b0, startStrobe}, 16'h0, "R9 no strobe when running");
    chkMain("R9 running hold");

    // R10 init strobe
    wrMain(16'h0041, '0);
    check({15'b0, initStrobe}, 16'h1, "R10 init strobe");
    chkMain("R10 unstored bits");

    // R4 write-one-clear group
    events(7'h79);
    chkMain("R4 error set");
    wrMain(16'h0040, '0);
    chkMain("R4 zero write keeps");
    wrMain(16'h5840, '0);
    chkMain("R4 partial clear");
    wrMain(16'h2140, '0);
    chkMain("R4 clear rest");

    // R5 receive/transmit flags every third write
    events(7'h06);
    clears = 0;
    for (int i = 0; i < 3; i++) begin
      wrMain(16'h0640, '0);
      chkMain("R5 rx/tx clear cadence");
      if (mSt[2:1] == 2'b00 && clears == 0) clears = i + 1;
    end
    check(16'(clears != 0), 16'h1, "R5 one clear in three writes");

    // R6 event beats clearing write
    wrMain(16'h0140, 7'h01);
    chkMain("R6 same-cycle event wins");

    // R7 mask write alone does not recompute INTR
    wrMain(16'h0004, '0);
    check({15'b0, stopStrobe}, 16'h1, "R3 stop strobe");
    chkMain("R3 stop word");
    wrIdx(3, 16'h0100); mMask = 5'h01;
    wrMain(16'h0040, '0);
    events(7'h01);
    chkMain("R7 masked source");
    wrIdx(3, 16'h0000); mMask = 5'h00;
    chkMain("R7 held after mask write");
    wrMain(16'h0040, '0);
    chkMain("R7 recomputed on write");
    events(7'h60);
    chkMain("R7 unmaskable bits ignored");

    // sweep: all masks by all event patterns
    for (int mk = 0; mk < 32; mk++) begin
      wrIdx(3, 16'(mk << 8)); mMask = mk[4:0];
      for (int p = 0; p < 128; p++) begin
        wrMain(16'h0004, '0);
        wrMain(16'h0040, '0);
        events(p[6:0]);
        chkMain("R7 sweep");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule